// File: doc/BRIEF.md
# Nested Loop Iteration Counter

This block keeps the iteration count of the innermost running loop and parks the counts of enclosing loops in a small last-in, first-out store. A count of N is loaded straight from a 16-bit data bus (the low 14 bits are used), and the counter reports "expired" while it holds 1. The loop-end logic asks for a test-and-decrement each pass, so a loaded N gives exactly N passes. When the test finds the count expired, the next outer count comes back from the store automatically.

A normal load saves the current count before replacing it, but only if that count is valid. The count is not valid after reset, and it is not valid after an expired test that finds the store empty. An overwrite load replaces the count without saving anything. A manual pop brings back the previous count for an early loop exit. A test-only strobe reports the condition and changes nothing. The read port shows the count zero-extended to 16 bits at all times.

Top module: `loop_count_unit`

## Requirements
- R1: `rd_data` always equals the count with bits 15:14 zero, and presenting or observing it changes no state.
- R2: `expired` is 1 exactly when the count equals 1; `cond_hit` is 1 when `expired` is 1 and either `dec_req` or `tst_req` is high.
- R3: A normal load (`ld_en`) while the count is valid pushes the old count, and the count takes `bus_in[13:0]` on the next cycle.
- R4: An overwrite load (`ow_en` without `ld_en`) replaces the count and never pushes; if both strobes are high, the normal load applies.
- R5: `dec_req` when the count is not 1 decrements it by one. A count of 0 stays at 0.
- R6: `tst_req` alone leaves the count and the store unchanged.
- R7: `dec_req` when the count is 1 and the store holds entries pops the top entry into the count.
- R8: The count becomes invalid (and reads 0) after `dec_req` at count 1 with an empty store. A normal load while the count is invalid pushes nothing.
- R9: `pop_req` restores the most recently saved count. When the store is empty, it leaves the count invalid and 0.
- R10: A push while all 4 entries are occupied is discarded, so the older entries are kept. It sets `stk_ovf`, which stays 1 until reset.
- R11: `stk_empty` is 1 exactly when no saved entries remain. Pops on an empty store leave it at 1.
- R12: Priority is load over `dec_req`, and `dec_req` over `pop_req`. A load in the same cycle as `pop_req` ignores the pop.
- R13: After reset, the count is 0 and invalid, `stk_empty` is 1, and `stk_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Load data; bits 13:0 are used |
| ld_en | input | 1 | Normal load (saves a valid old count) |
| ow_en | input | 1 | Overwrite load (never saves) |
| dec_req | input | 1 | Test-and-decrement strobe |
| tst_req | input | 1 | Test-only strobe |
| pop_req | input | 1 | Manual pop strobe |
| rd_data | output | 16 | Zero-extended count |
| expired | output | 1 | Count equals 1 |
| cond_hit | output | 1 | Result of the current test strobe |
| stk_empty | output | 1 | No saved counts remain |
| stk_ovf | output | 1 | Sticky store overflow |

## Verification
The hardest state to reach is a full store that is then asked to take another push. Reaching it needs five back-to-back valid normal loads. After that, pops must return the four oldest counts in reverse order, which shows that the dropped value never reached the store. The directed sequence first makes the count invalid through an expired decrement, to show that this path pushes nothing. It then builds the overflow and unwinds it with manual pops past empty. A long random phase follows, weighted toward loads and expired decrements, and is compared every cycle against a queue-based model.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_LOAD,
    OP_DEC,
    OP_RESTORE,
    OP_DROP
  } cnt_op_e;
endpackage

// File: rtl/lcu_counter.sv
module lcu_counter
  import lcu_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_op_e       op,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] restore_val,
  output logic [CW-1:0] cnt_q,
  output logic          valid_q,
  output logic          expired
);
  // decrement that holds at zero instead of wrapping
  function automatic logic [CW-1:0] dec_hold(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic is_one(input logic [CW-1:0] v);
    return v == CW'(1);
  endfunction

  assign expired = is_one(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      case (op)
        OP_LOAD:    begin cnt_q <= load_val;    valid_q <= 1'b1; end
        OP_DEC:     cnt_q <= dec_hold(cnt_q);
        OP_RESTORE: begin cnt_q <= restore_val; valid_q <= 1'b1; end
        OP_DROP:    begin cnt_q <= '0;          valid_q <= 1'b0; end
        default:    ;
      endcase
    end
  end

  // R5: a plain decrement moves the count down by exactly one
  a_r5_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DEC && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R8: dropping always leaves an invalid zero count
  a_r8_drop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DROP) |=> (cnt_q == '0 && !valid_q));
endmodule

// File: rtl/lcu_stack.sv
module lcu_stack #(
  parameter int CW    = 14,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [CW-1:0] din,
  output logic [CW-1:0] top,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic          empty,
  output logic          full,
  output logic          ovf
);
  localparam int OW = $clog2(DEPTH+1);

  logic [CW-1:0] slot_w [DEPTH];
  logic          push_drop;
  logic          push_take;
  logic          pop_take;

  assign full      = (occ == OW'(DEPTH));
  assign empty     = (occ == '0);
  assign push_take = push && !full;
  assign push_drop = push && full;
  assign pop_take  = pop && !empty;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [CW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (push_take && occ == OW'(i)) q <= din;
    end
    assign slot_w[i] = q;
  end

  always_comb begin
    top = '0;
    for (int k = 0; k < DEPTH; k++)
      if (occ == OW'(k + 1)) top = slot_w[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
      ovf <= 1'b0;
    end else begin
      if (push_take)      occ <= occ + 1'b1;
      else if (pop_take)  occ <= occ - 1'b1;
      if (push_drop)      ovf <= 1'b1;
    end
  end

  // R10: overflow flag never clears outside reset
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R10: a push into a full store keeps the occupancy
  a_r10_full_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (occ == OW'(DEPTH) && ovf));
  // R11: occupancy never exceeds the depth
  a_r11_occ_range: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  // R12: control never asks for push and pop together
  a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/loop_count_unit.sv
module loop_count_unit
  import lcu_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 14,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  input  logic          ld_en,
  input  logic          ow_en,
  input  logic          dec_req,
  input  logic          tst_req,
  input  logic          pop_req,
  output logic [DW-1:0] rd_data,
  output logic          expired,
  output logic          cond_hit,
  output logic          stk_empty,
  output logic          stk_ovf
);
  localparam int OW = $clog2(DEPTH+1);

  cnt_op_e       op;
  logic [CW-1:0] cnt_q;
  logic          valid_q;
  logic [CW-1:0] top;
  logic [OW-1:0] occ;
  logic          full;
  logic          push;
  logic          pop;
  logic          any_load;

  function automatic logic [DW-1:0] widen(input logic [CW-1:0] v);
    return {{(DW-CW){1'b0}}, v};
  endfunction

  assign any_load = ld_en | ow_en;

  // priority: load > decrement > manual pop
  always_comb begin
    op   = OP_HOLD;
    push = 1'b0;
    pop  = 1'b0;
    if (any_load) begin
      op   = OP_LOAD;
      push = ld_en && valid_q;
    end else if (dec_req) begin
      if (expired) begin
        pop = !stk_empty;
        op  = stk_empty ? OP_DROP : OP_RESTORE;
      end else begin
        op = OP_DEC;
      end
    end else if (pop_req) begin
      pop = !stk_empty;
      op  = stk_empty ? OP_DROP : OP_RESTORE;
    end
  end

  lcu_counter #(.CW(CW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .load_val    (bus_in[CW-1:0]),
    .restore_val (top),
    .cnt_q       (cnt_q),
    .valid_q     (valid_q),
    .expired     (expired)
  );

  lcu_stack #(.CW(CW), .DEPTH(DEPTH)) u_stk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .din   (cnt_q),
    .top   (top),
    .occ   (occ),
    .empty (stk_empty),
    .full  (full),
    .ovf   (stk_ovf)
  );

  assign rd_data  = widen(cnt_q);
  assign cond_hit = (dec_req | tst_req) & expired;

  // R1: the upper read bits are always zero
  always_comb a_r1_pad: assert (rd_data[DW-1:CW] == '0);

  // R3: valid normal load below full grows the store and takes the bus
  a_r3_load_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && valid_q && !full) |=> (occ == $past(occ) + 1'b1 &&
                                     cnt_q == $past(bus_in[CW-1:0])));
  // R4: overwrite alone leaves the store untouched
  a_r4_ow_nopush: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_en && !ld_en) |=> ($stable(occ) && valid_q));
  // R6: test-only keeps the count
  a_r6_tst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_req && !any_load && !dec_req && !pop_req) |=> ($stable(cnt_q) && $stable(occ)));
  // R7: expired decrement with saved entries shrinks the store
  a_r7_auto_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !any_load && expired && !stk_empty) |=> (occ == $past(occ) - 1'b1));
  // R8: load of an invalid count saves nothing
  a_r8_no_invalid_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !valid_q) |=> $stable(occ));
  // R12: a load in the same cycle as a pop ignores the pop
  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (any_load && pop_req && !(ld_en && valid_q)) |=> $stable(occ));
endmodule

// File: tb/sim_loop_count_unit.sv
module sim_loop_count_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_in = '0;
  logic        ld_en = 0, ow_en = 0, dec_req = 0, tst_req = 0, pop_req = 0;
  logic [15:0] rd_data;
  logic        expired, cond_hit, stk_empty, stk_ovf;

  int total = 0;
  int bad = 0;

  // reference model state
  int m_cnt = 0;
  bit m_val = 0;
  bit m_ovf = 0;
  int m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_count_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_en(ld_en), .ow_en(ow_en),
    .dec_req(dec_req), .tst_req(tst_req), .pop_req(pop_req), .rd_data(rd_data),
    .expired(expired), .cond_hit(cond_hit), .stk_empty(stk_empty), .stk_ovf(stk_ovf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_state(input string req);
    chk(req,   "rd_data", int'(rd_data), m_cnt);
    chk("R2",  "expired", int'(expired), int'(m_cnt == 1));
    chk("R11", "stk_empty", int'(stk_empty), int'(m_q.size() == 0));
    chk("R10", "stk_ovf", int'(stk_ovf), int'(m_ovf));
  endtask

  task automatic model_restore();
    if (m_q.size() > 0) begin
      m_cnt = m_q.pop_back();
      m_val = 1;
    end else begin
      m_cnt = 0;
      m_val = 0;
    end
  endtask

  task automatic model_step();
    if (ld_en || ow_en) begin
      if (ld_en && m_val) begin
        if (m_q.size() < DEPTH) m_q.push_back(m_cnt);
        else m_ovf = 1;
      end
      m_cnt = int'(bus_in[13:0]);
      m_val = 1;
    end else if (dec_req) begin
      if (m_cnt == 1) model_restore();
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
    end else if (pop_req) begin
      model_restore();
    end
  endtask

  // one clock: drive after negedge, check combinational result, clock, check state
  task automatic cyc(input string req, input bit ld, input bit ow, input bit dc,
                     input bit ts, input bit pp, input logic [15:0] d);
    ld_en = ld; ow_en = ow; dec_req = dc; tst_req = ts; pop_req = pp; bus_in = d;
    #1;
    chk("R2", "cond_hit", int'(cond_hit), int'((dc || ts) && m_cnt == 1));
    @(posedge clk);
    model_step();
    @(negedge clk);
    ld_en = 0; ow_en = 0; dec_req = 0; tst_req = 0; pop_req = 0;
    compare_state(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_state("R13");
    rst_n = 1'b1;
    @(negedge clk);
    compare_state("R13");

    // R8: load while invalid saves nothing
    cyc("R8", 1, 0, 0, 0, 0, 16'd5);
    // R6: test-only holds
    cyc("R6", 0, 0, 0, 1, 0, 16'h0);
    cyc("R6", 0, 0, 0, 1, 0, 16'h0);
    // R3: valid load pushes 5
    cyc("R3", 1, 0, 0, 0, 0, 16'd3);
    // R5: decrement to 1
    cyc("R5", 0, 0, 1, 0, 0, 16'h0);
    cyc("R5", 0, 0, 1, 0, 0, 16'h0);
    cyc("R6", 0, 0, 0, 1, 0, 16'h0);   // expired test-only keeps 1
    // R7: expired decrement restores 5
    cyc("R7", 0, 0, 1, 0, 0, 16'h0);
    for (int i = 0; i < 4; i++) cyc("R5", 0, 0, 1, 0, 0, 16'h0);
    // R8: expired with empty store -> invalid 0
    cyc("R8", 0, 0, 1, 0, 0, 16'h0);
    cyc("R5", 0, 0, 1, 0, 0, 16'h0);   // zero holds
    cyc("R8", 1, 0, 0, 0, 0, 16'd7);   // no push
    // R10: fill store and overflow
    cyc("R3", 1, 0, 0, 0, 0, 16'd10);
    cyc("R3", 1, 0, 0, 0, 0, 16'd11);
    cyc("R3", 1, 0, 0, 0, 0, 16'd12);
    cyc("R3", 1, 0, 0, 0, 0, 16'd13);
    cyc("R10", 1, 0, 0, 0, 0, 16'd14);
    // R9: manual pops return 12,11,10,7 then empty
    for (int i = 0; i < 6; i++) cyc("R9", 0, 0, 0, 0, 1, 16'h0);
    // R12: load with pop
    cyc("R12", 1, 0, 0, 0, 0, 16'd20);
    cyc("R12", 1, 0, 0, 0, 0, 16'd21);
    cyc("R12", 1, 0, 0, 0, 1, 16'd22);
    cyc("R12", 0, 0, 1, 0, 1, 16'h0);  // dec beats pop
    // R4: overwrite with valid count, and both strobes
    cyc("R4", 0, 1, 0, 0, 0, 16'd30);
    cyc("R4", 1, 1, 0, 0, 0, 16'd31);
    // R1: upper bus bits dropped
    cyc("R1", 0, 1, 0, 0, 0, 16'hFFFF);
    cyc("R1", 1, 0, 0, 0, 0, 16'hC001);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      logic [15:0] d = 16'($urandom_range(0, 6)) | (16'($urandom_range(0, 3)) << 14);
      if (r < 20)      cyc("R3", 1, 0, $urandom_range(0,1) == 1, 0, $urandom_range(0,1) == 1, d);
      else if (r < 27) cyc("R4", 0, 1, 0, 0, 0, d);
      else if (r < 70) cyc("R7", 0, 0, 1, 0, $urandom_range(0,1) == 1, d);
      else if (r < 80) cyc("R6", 0, 0, 0, 1, 0, d);
      else if (r < 92) cyc("R9", 0, 0, 0, 0, 1, d);
      else begin
        rst_n = 1'b0;
        m_cnt = 0; m_val = 0; m_ovf = 0; m_q.delete();
        @(negedge clk);
        compare_state("R13");
        rst_n = 1'b1;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule